// File: doc/BRIEF.md
# Two-Client Arbitration Tree Cell

This cell is the node from which a multi-way arbiter is assembled as a balanced binary tree. Each cell serves two children over four-phase request/grant handshakes, and the children start those handshakes. Toward its parent the cell acts as an ordinary four-phase client. A two-way mutex inside the cell chooses one child. Glue logic then asks the parent for the resource and hands the parent's grant down to the chosen child only. The mutex decision stays internal and is not visible on the interface.

The cell is modelled as clocked logic. The parameter `EAGER` selects between two timing variants. With `EAGER=0` the upward request is raised only after the local mutex has registered its choice, so decisions at successive tree levels happen one after another. With `EAGER=1` the upward request is raised as soon as any child requests, and the local decision is made while the parent is deciding. Grants use the strict style: a parent handshake is always completed and restarted before a second child can be served, so at most one child grant is ever high.

Top module: `tac_cell`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `gnt_a`, `gnt_b` and `par_req` are all 0.
- R2: `gnt_a` and `gnt_b` are never 1 in the same cycle, and the chosen child stays chosen until its handshake and the parent handshake have both completed.
- R3: A child grant rises only while `par_req` is 1, and only if `par_gnt` was 1 in the previous cycle.
- R4: When both children request in the same cycle and no child is being served, the child not served most recently wins. After reset, child A counts as the winner on a tie.
- R5: With `EAGER=0`, `par_req` rises two clock edges after a lone child request is first sampled, and it is still 0 after the first edge.
- R6: With `EAGER=1`, `par_req` rises on the first clock edge that samples a child request.
- R7: The chosen child's grant rises on the first edge at which `par_gnt` is sampled high while a child is chosen. With a parent that answers within half a cycle, this is edge 2 for `EAGER=1` and edge 3 for `EAGER=0`, counted from the request.
- R8: On the first edge that samples the served child's request low, its grant and `par_req` both fall together.
- R9: While the served child holds both its request and its grant, `par_req` stays at 1.
- R10: A second pending child is granted only after `par_gnt` has returned to 0 and `par_req` has risen again. `par_req` never rises while `par_gnt` is still 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_a | input | 1 | Request from child A (four-phase) |
| req_b | input | 1 | Request from child B (four-phase) |
| gnt_a | output | 1 | Grant to child A |
| gnt_b | output | 1 | Grant to child B |
| par_req | output | 1 | Request toward the parent cell |
| par_gnt | input | 1 | Grant from the parent cell |

## Verification
Suppose the cell loses track of which child it chose. The error reaches the ports within one edge of the parent grant. It shows as both child grants high together, or as a grant to a child that is not requesting. If the upstream phase tracking is corrupted, `par_req` falls while a child is still inside its critical section, or rises again before the parent has released. The parent handshake exposes this in the very next cycle. Cycle-exact latency checks in both modes tell a premature upward request apart from a late one, and alternating ties tell a stuck tie-break apart from a working one.

// File: rtl/tac_pkg.sv
package tac_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_A    = 2'd1,
        OWN_B    = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        UP_IDLE = 2'd0,
        UP_WAIT = 2'd1,
        UP_HOLD = 2'd2,
        UP_DROP = 2'd3
    } up_phase_e;

    typedef struct packed {
        owner_e owner;
        logic   last_b;
    } mutex_st_t;

    typedef struct packed {
        up_phase_e phase;
        logic      gnt_a;
        logic      gnt_b;
        logic      par_req;
    } link_st_t;

endpackage

// File: rtl/tac_mutex.sv
module tac_mutex
    import tac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_a,
    input  logic   req_b,
    input  logic   release_i,
    output owner_e owner_o
);

    mutex_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.owner != OWN_NONE) begin
            if (release_i) begin
                st_d.owner = OWN_NONE;
            end
        end else if (req_a && req_b) begin
            // tie: serve the child that did not win last time
            st_d.owner  = st_q.last_b ? OWN_A : OWN_B;
            st_d.last_b = !st_q.last_b;
        end else if (req_a) begin
            st_d.owner  = OWN_A;
            st_d.last_b = 1'b0;
        end else if (req_b) begin
            st_d.owner  = OWN_B;
            st_d.last_b = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.owner  <= OWN_NONE;
            st_q.last_b <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_o = st_q.owner;

    // R2
    owner_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner != OWN_NONE) |=> (st_q.owner == $past(st_q.owner) || st_q.owner == OWN_NONE));

    // R2
    owner_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.owner != 2'd3);

endmodule

// File: rtl/tac_uplink.sv
module tac_uplink
    import tac_pkg::*;
#(
    parameter bit EAGER = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_a,
    input  logic   req_b,
    input  logic   par_gnt,
    input  owner_e owner_i,
    output logic   gnt_a,
    output logic   gnt_b,
    output logic   par_req,
    output logic   release_o
);

    link_st_t st_d, st_q;
    logic     ask_w;
    logic     win_req_w;

    generate
        if (EAGER) begin : g_eager
            assign ask_w = req_a || req_b;
        end else begin : g_serial
            assign ask_w = (owner_i != OWN_NONE);
        end
    endgenerate

    assign win_req_w = (owner_i == OWN_A) ? req_a :
                       (owner_i == OWN_B) ? req_b : 1'b0;

    always_comb begin
        st_d      = st_q;
        release_o = 1'b0;
        case (st_q.phase)
            UP_IDLE: begin
                if (ask_w) begin
                    st_d.phase   = UP_WAIT;
                    st_d.par_req = 1'b1;
                end
            end
            UP_WAIT: begin
                if (par_gnt && owner_i != OWN_NONE) begin
                    st_d.phase = UP_HOLD;
                    st_d.gnt_a = (owner_i == OWN_A);
                    st_d.gnt_b = (owner_i == OWN_B);
                end
            end
            UP_HOLD: begin
                if (!win_req_w) begin
                    st_d.phase   = UP_DROP;
                    st_d.gnt_a   = 1'b0;
                    st_d.gnt_b   = 1'b0;
                    st_d.par_req = 1'b0;
                end
            end
            UP_DROP: begin
                if (!par_gnt) begin
                    st_d.phase = UP_IDLE;
                    release_o  = 1'b1;
                end
            end
            default: st_d.phase = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= UP_IDLE;
            st_q.gnt_a   <= 1'b0;
            st_q.gnt_b   <= 1'b0;
            st_q.par_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_a   = st_q.gnt_a;
    assign gnt_b   = st_q.gnt_b;
    assign par_req = st_q.par_req;

    // R2
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_a && gnt_b));

    // R3
    grant_after_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_a) || $rose(gnt_b)) |-> ($past(par_gnt) && par_req));

    // R9
    hold_upstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_a && req_a) || (gnt_b && req_b)) |=> par_req);

    // R8
    release_order_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_a) |-> (!$past(req_a) && !par_req));

    // R8
    release_order_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_b) |-> (!$past(req_b) && !par_req));

    // R10
    restart_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_req) |-> !$past(par_gnt));

endmodule

// File: rtl/tac_cell.sv
module tac_cell
    import tac_pkg::*;
#(
    parameter bit EAGER = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    output logic gnt_a,
    output logic gnt_b,
    output logic par_req,
    input  logic par_gnt
);

    owner_e owner_w;
    logic   release_w;

    tac_mutex u_mutex (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_a     (req_a),
        .req_b     (req_b),
        .release_i (release_w),
        .owner_o   (owner_w)
    );

    tac_uplink #(.EAGER(EAGER)) u_uplink (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_a     (req_a),
        .req_b     (req_b),
        .par_gnt   (par_gnt),
        .owner_i   (owner_w),
        .gnt_a     (gnt_a),
        .gnt_b     (gnt_b),
        .par_req   (par_req),
        .release_o (release_w)
    );

    // R2
    crit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((req_a && gnt_a) && (req_b && gnt_b)));

    // R3
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gnt_a) |-> $past(req_a)) and ($rose(gnt_b) |-> $past(req_b)));

endmodule

// File: tb/tac_cell_tb.sv
module tac_cell_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ra, rb, pg;
    logic [1:0] ga, gb, pr;
    int         pdly;
    int         pcnt [2];
    int         nchk = 0;
    int         nerr = 0;

    always #10 clk = ~clk;

    tac_cell #(.EAGER(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_a(ra[0]), .req_b(rb[0]),
        .gnt_a(ga[0]), .gnt_b(gb[0]), .par_req(pr[0]), .par_gnt(pg[0])
    );

    tac_cell #(.EAGER(1'b1)) u_dut_c (
        .clk(clk), .rst_n(rst_n), .req_a(ra[1]), .req_b(rb[1]),
        .gnt_a(ga[1]), .gnt_b(gb[1]), .par_req(pr[1]), .par_gnt(pg[1])
    );

    // behavioural parents: follow par_req after pdly extra cycles
    always @(negedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                pg[m]   <= 1'b0;
                pcnt[m] <= 0;
            end else if (pr[m] != pg[m]) begin
                if (pcnt[m] >= pdly) begin
                    pg[m]   <= pr[m];
                    pcnt[m] <= 0;
                end else begin
                    pcnt[m] <= pcnt[m] + 1;
                end
            end else begin
                pcnt[m] <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic get_g(input int m, input bit sel_b);
        return sel_b ? gb[m] : ga[m];
    endfunction

    task automatic wait_g(input int m, input bit sel_b, input string tag);
        for (int k = 0; k < 60 && get_g(m, sel_b) !== 1'b1; k++) step(1);
        chk(tag, get_g(m, sel_b), 1'b1);
    endtask

    task automatic t_reset();
        for (int m = 0; m < 2; m++) begin
            chk("R1 gnt_a after reset", ga[m], 1'b0);
            chk("R1 gnt_b after reset", gb[m], 1'b0);
            chk("R1 par_req after reset", pr[m], 1'b0);
        end
    endtask

    // lone request: exact latency per mode, hold, release
    task automatic t_latency(input int m);
        pdly = 0;
        ra[m] = 1'b1;
        step(1);
        if (m == 1) chk("R6 eager par_req after edge 1", pr[m], 1'b1);
        else        chk("R5 serial par_req low after edge 1", pr[m], 1'b0);
        step(1);
        if (m == 0) chk("R5 serial par_req after edge 2", pr[m], 1'b1);
        chk("R7 gnt_a after edge 2", ga[m], (m == 1));
        step(1);
        chk("R7 gnt_a after edge 3", ga[m], 1'b1);
        chk("R2 gnt_b idle while A served", gb[m], 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1);
            chk("R9 par_req held during use", pr[m], 1'b1);
        end
        ra[m] = 1'b0;
        step(1);
        chk("R8 gnt_a dropped", ga[m], 1'b0);
        chk("R8 par_req dropped", pr[m], 1'b0);
        step(4);
    endtask

    // tie after A was served: B wins, then A handed over via a new parent handshake
    task automatic t_contend(input int m);
        pdly = 2;
        ra[m] = 1'b1;
        rb[m] = 1'b1;
        wait_g(m, 1'b1, "R4 tie goes to B after A served");
        chk("R2 gnt_a low during B tenure", ga[m], 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1);
            chk("R9 par_req held for B", pr[m], 1'b1);
            chk("R2 exclusion under contention", ga[m] & gb[m], 1'b0);
        end
        rb[m] = 1'b0;
        step(1);
        chk("R8 gnt_b dropped", gb[m], 1'b0);
        chk("R10 par_req low before handover", pr[m], 1'b0);
        chk("R10 gnt_a not yet granted", ga[m], 1'b0);
        step(1);
        chk("R10 gnt_a waits for parent release", ga[m], 1'b0);
        wait_g(m, 1'b0, "R10 pending A served after restart");
        chk("R3 par_req high with grant", pr[m], 1'b1);
        ra[m] = 1'b0;
        step(1);
        chk("R8 gnt_a dropped after handover", ga[m], 1'b0);
        step(8);
    endtask

    // tie after A was served last: B first again; then after B, tie gives A
    task automatic t_alternate(input int m);
        pdly = 1;
        rb[m] = 1'b1;
        wait_g(m, 1'b1, "R4 lone B served");
        rb[m] = 1'b0;
        step(8);
        ra[m] = 1'b1;
        rb[m] = 1'b1;
        wait_g(m, 1'b0, "R4 tie goes to A after B served");
        chk("R2 gnt_b low while A wins", gb[m], 1'b0);
        ra[m] = 1'b0;
        wait_g(m, 1'b1, "R10 B follows A");
        rb[m] = 1'b0;
        step(8);
    endtask

    initial begin
        ra = '0;
        rb = '0;
        pdly = 0;
        rst_n = 1'b0;
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        for (int m = 0; m < 2; m++) begin
            t_latency(m);
            t_contend(m);
            t_alternate(m);
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule